// File: doc/BRIEF.md
# Stepper Excitation Position Sequencer

This block turns a stream of step clock pulses into coil current targets for one two-coil stepping motor. It keeps an electrical phase index with 256 positions per electrical cycle. It converts that index into two signed amplitude codes, one per coil, from a quarter-wave sine table. Five excitation modes set how far each step moves the index: two-phase, half-step with full torque, plain half-step, fine microstep and coarse microstep. A driver stage outside the block turns the codes into regulated coil currents.

Configuration is presented on parallel inputs and takes effect on the rising edge of a separate latch strobe. The configuration covers mode, direction, hold, counter zeroing and output enable. Hold freezes an internal copy of the step clock, so steps arriving during hold are lost. Zeroing parks the position at the origin until it is cleared. Output-off raises a high-impedance flag, and the position keeps tracking the step clock while the flag is up. A new mode or direction is only acted on at the next internal step edge. When a coarse mode is entered, the first step lands on a defined diagonal point. All inputs are taken to be synchronous to `clk`.

Top module: `step_phase_seq`

## Requirements
- R1: After reset, coil A is +255, coil B is 0, the high-impedance flag is 1, and the pending and active mode is fine microstep with increasing-index direction.
- R2: For phase index p (0..255), coil B is S(p) and coil A is S(p+64 mod 256). S is built from a quarter table T(u) = round(255*4u(128-u)/(20480-u(128-u))) for u = 0..64. On quadrant q = p/64 with remainder r, the magnitude is T(r) for even q and T(64-r) for odd q, and the sign is negative for q of 2 or 3.
- R3: Mode codes are 0 two-phase, 1 half-step full torque, 2 half-step, 3 fine microstep, 4 coarse microstep. On a normal step the index moves by 64, 32, 32, 1 or 2 respectively, modulo 256.
- R4: With the direction input at 0 the index increases on each step, so coil B lags coil A by 90 degrees. With it at 1 the index decreases, so coil B leads coil A.
- R5: Mode and direction are captured on the strobe rising edge. They change nothing at the outputs until the next internal step rising edge, and that step uses them.
- R6: In modes 0 and 1, at a diagonal index (p mod 64 = 32), both coils output magnitude 255 with the signs of R2.
- R7: The landing step applies in modes 0, 1 and 2 when the mode differs from the active one or the index lies off that mode's grid. The grid is the diagonals for mode 0 and multiples of 32 for modes 1 and 2. The landing step goes to the nearest diagonal in the direction of travel. If the index is already on a diagonal, it takes a normal step instead.
- R8: While hold is latched, the internal step clock keeps the external level captured at the strobe, and no external clock activity moves the index.
- R9: When hold is released, the internal clock follows the external one again. Releasing while the captured level is low and the external level is high causes one step. Releasing while both are high causes none.
- R10: A strobe with zeroing set forces the index to 0 (coil A +255, coil B 0) and ignores steps. After a strobe clears zeroing, stepping resumes from 0.
- R11: A strobe with output enable at 0 sets the high-impedance flag, and a strobe with it at 1 clears the flag. Steps keep moving the codes while the flag is set.
- R12: A strobe carrying a mode code of 5, 6 or 7 leaves the pending mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | External step clock level |
| strobe_i | input | 1 | Configuration latch strobe, acts on its rising edge |
| cfg_mode_i | input | 3 | Excitation mode code |
| cfg_ccw_i | input | 1 | Direction: 0 increasing index, 1 decreasing |
| cfg_hold_i | input | 1 | Hold request |
| cfg_zero_i | input | 1 | Counter zeroing request |
| cfg_oe_i | input | 1 | Output enable request |
| coil_a_o | output | 9 | Signed amplitude code for coil A |
| coil_b_o | output | 9 | Signed amplitude code for coil B |
| hiz_o | output | 1 | High-impedance flag for both coils |

## Verification
A full electrical cycle of fine microsteps compares every one of the 256 index values against the arithmetic sine table, which separates quadrant sign and mirror faults from table faults. Runs in the reverse direction and in each coarse mode show whether the step size and the direction are right. The landing cases pick apart an off-grid entry, an entry at an axis and an entry already on a diagonal. The hold cases run with the captured level low and then high, so that stepping on release can be told apart from holding on release. The zeroing, output-off and invalid-code strobes are each followed by steps, so any effect they leak onto the index shows at the coil codes.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;

  typedef enum logic [2:0] {
    EXC_TWO          = 3'd0,
    EXC_HALF_FT      = 3'd1,
    EXC_HALF         = 3'd2,
    EXC_MICRO_FINE   = 3'd3,
    EXC_MICRO_COARSE = 3'd4
  } exc_mode_e;

  function automatic logic mode_code_ok(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic mode_is_coarse(input exc_mode_e m);
    return (m == EXC_TWO) || (m == EXC_HALF_FT) || (m == EXC_HALF);
  endfunction

  function automatic logic mode_full_torque(input exc_mode_e m);
    return (m == EXC_TWO) || (m == EXC_HALF_FT);
  endfunction

endpackage

// File: rtl/stepseq_qrom.sv
module stepseq_qrom #(
  parameter int QB = 6,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic [QB:0]   addr_i,
  output logic [MW-1:0] mag_o
);
  localparam int QTR  = 1 << QB;
  localparam int HALF = 2 * QTR;
  localparam int FULL = (1 << MW) - 1;

  function automatic logic [MW-1:0] qval(input int u);
    longint num;
    longint den;
    den = longint'(5 * HALF * HALF / 4) - longint'(u * (HALF - u));
    num = longint'(FULL) * 4 * longint'(u) * longint'(HALF - u);
    return MW'((num + den / 2) / den);
  endfunction

  logic [MW-1:0] mem [0:QTR];

  initial begin
    for (int i = 0; i <= QTR; i++) mem[i] = qval(i);
  end

  always_ff @(posedge clk) begin
    mag_o <= mem[addr_i];
  end
endmodule

// File: rtl/stepseq_cfg_latch.sv
module stepseq_cfg_latch
  import stepseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step_i,
  input  logic       strobe_i,
  input  logic [2:0] cfg_mode_i,
  input  logic       cfg_ccw_i,
  input  logic       cfg_hold_i,
  input  logic       cfg_zero_i,
  input  logic       cfg_oe_i,
  output logic       step_evt_o,
  output exc_mode_e  pend_mode_o,
  output logic       pend_ccw_o,
  output logic       zero_now_o,
  output logic       zero_q_o,
  output logic       hold_q_o,
  output logic       oe_q_o,
  output logic       stb_rise_o
);
  logic      stb_q;
  logic      int_lvl;
  logic      int_nxt;
  logic      hold_r;
  logic      zero_r;
  logic      oe_r;
  logic      ccw_r;
  exc_mode_e mode_r;

  assign stb_rise_o = strobe_i & ~stb_q;
  assign int_nxt    = hold_r ? int_lvl : step_i;
  assign step_evt_o = int_nxt & ~int_lvl;
  assign zero_now_o = stb_rise_o ? cfg_zero_i : zero_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q   <= 1'b0;
      int_lvl <= 1'b0;
      hold_r  <= 1'b0;
      zero_r  <= 1'b0;
      oe_r    <= 1'b0;
      ccw_r   <= 1'b0;
      mode_r  <= EXC_MICRO_FINE;
    end else begin
      stb_q   <= strobe_i;
      int_lvl <= int_nxt;
      if (stb_rise_o) begin
        hold_r <= cfg_hold_i;
        zero_r <= cfg_zero_i;
        oe_r   <= cfg_oe_i;
        ccw_r  <= cfg_ccw_i;
        if (mode_code_ok(cfg_mode_i)) mode_r <= exc_mode_e'(cfg_mode_i);
      end
    end
  end

  assign pend_mode_o = mode_r;
  assign pend_ccw_o  = ccw_r;
  assign zero_q_o    = zero_r;
  assign hold_q_o    = hold_r;
  assign oe_q_o      = oe_r;
endmodule

// File: rtl/stepseq_phase.sv
module stepseq_phase
  import stepseq_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_evt_i,
  input  logic          zero_i,
  input  exc_mode_e     pend_mode_i,
  input  logic          pend_ccw_i,
  output logic [PW-1:0] pos_o,
  output exc_mode_e     act_mode_o
);
  localparam int QB = PW - 2;
  localparam logic [PW-1:0] ST_FINE   = PW'(1 << (PW - 8));
  localparam logic [PW-1:0] ST_COARSE = PW'(2 << (PW - 8));
  localparam logic [PW-1:0] ST_HALF   = PW'(1 << (PW - 3));
  localparam logic [PW-1:0] ST_TWO    = PW'(1 << (PW - 2));
  localparam logic [QB-1:0] MID       = QB'(1 << (QB - 1));

  logic [PW-1:0] pos_q;
  logic [PW-1:0] pos_nxt;
  logic [PW-1:0] stp;
  exc_mode_e     act_q;
  logic [1:0]    quad;
  logic [1:0]    land_q;
  logic [QB-1:0] low;
  logic          on_grid;
  logic          need_land;

  assign quad = pos_q[PW-1:QB];
  assign low  = pos_q[QB-1:0];

  always_comb begin
    case (pend_mode_i)
      EXC_TWO:          stp = ST_TWO;
      EXC_HALF_FT,
      EXC_HALF:         stp = ST_HALF;
      EXC_MICRO_COARSE: stp = ST_COARSE;
      default:          stp = ST_FINE;
    endcase
  end

  always_comb begin
    case (pend_mode_i)
      EXC_TWO:     on_grid = (low == MID);
      EXC_HALF_FT,
      EXC_HALF:    on_grid = (low[QB-2:0] == '0);
      default:     on_grid = 1'b1;
    endcase
  end

  assign need_land = mode_is_coarse(pend_mode_i) &&
                     ((pend_mode_i != act_q) || !on_grid) && (low != MID);

  always_comb begin
    if (!pend_ccw_i) land_q = (low < MID) ? quad : quad + 2'd1;
    else             land_q = (low > MID) ? quad : quad - 2'd1;
    if (need_land)       pos_nxt = {land_q, MID};
    else if (pend_ccw_i) pos_nxt = pos_q - stp;
    else                 pos_nxt = pos_q + stp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      act_q <= EXC_MICRO_FINE;
    end else if (zero_i) begin
      pos_q <= '0;
    end else if (step_evt_i) begin
      pos_q <= pos_nxt;
      act_q <= pend_mode_i;
    end
  end

  assign pos_o      = pos_q;
  assign act_mode_o = act_q;
endmodule

// File: rtl/stepseq_drive.sv
module stepseq_drive
  import stepseq_pkg::*;
#(
  parameter int PW   = 8,
  parameter int AMPW = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PW-1:0]        pos_i,
  input  exc_mode_e            act_mode_i,
  input  logic                 oe_i,
  output logic [1:0][AMPW-1:0] coil_o,
  output logic                 hiz_o
);
  localparam int QB  = PW - 2;
  localparam int QTR = 1 << QB;
  localparam int MW  = AMPW - 1;
  localparam logic signed [AMPW-1:0] FULL = AMPW'((1 << MW) - 1);
  localparam logic [QB:0]   QTR_A = (QB+1)'(QTR);
  localparam logic [QB-1:0] MID   = QB'(1 << (QB - 1));

  logic diag_d;

  always_ff @(posedge clk) begin
    if (rst) diag_d <= 1'b0;
    else     diag_d <= mode_full_torque(act_mode_i) && (pos_i[QB-1:0] == MID);
  end

  for (genvar c = 0; c < 2; c++) begin : g_coil
    logic [PW-1:0]          ph;
    logic [QB:0]            addr;
    logic [MW-1:0]          mag_rd;
    logic                   neg_d;
    logic signed [AMPW-1:0] mag_s;
    logic [AMPW-1:0]        out_q;

    assign ph   = pos_i + ((c == 0) ? PW'(QTR) : PW'(0));
    assign addr = ph[QB] ? (QTR_A - {1'b0, ph[QB-1:0]}) : {1'b0, ph[QB-1:0]};

    stepseq_qrom #(.QB(QB), .MW(MW)) u_rom (
      .clk    (clk),
      .addr_i (addr),
      .mag_o  (mag_rd)
    );

    assign mag_s = diag_d ? FULL : $signed({1'b0, mag_rd});

    always_ff @(posedge clk) begin
      if (rst) begin
        neg_d <= 1'b0;
        out_q <= (c == 0) ? FULL : '0;
      end else begin
        neg_d <= ph[PW-1];
        out_q <= neg_d ? -mag_s : mag_s;
      end
    end

    assign coil_o[c] = out_q;
  end

  always_ff @(posedge clk) begin
    if (rst) hiz_o <= 1'b1;
    else     hiz_o <= ~oe_i;
  end
endmodule

// File: rtl/step_phase_seq.sv
module step_phase_seq
  import stepseq_pkg::*;
#(
  parameter int PW   = 8,
  parameter int AMPW = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step_i,
  input  logic                   strobe_i,
  input  logic [2:0]             cfg_mode_i,
  input  logic                   cfg_ccw_i,
  input  logic                   cfg_hold_i,
  input  logic                   cfg_zero_i,
  input  logic                   cfg_oe_i,
  output logic signed [AMPW-1:0] coil_a_o,
  output logic signed [AMPW-1:0] coil_b_o,
  output logic                   hiz_o
);
  logic                 step_evt_w;
  exc_mode_e            pend_mode_w;
  exc_mode_e            act_mode_w;
  logic                 pend_ccw_w;
  logic                 zero_now_w;
  logic                 zero_q_w;
  logic                 hold_q_w;
  logic                 oe_q_w;
  logic                 stb_rise_w;
  logic [PW-1:0]        pos_w;
  logic [1:0][AMPW-1:0] coil_w;

  stepseq_cfg_latch u_cfg (
    .clk         (clk),
    .rst         (rst),
    .step_i      (step_i),
    .strobe_i    (strobe_i),
    .cfg_mode_i  (cfg_mode_i),
    .cfg_ccw_i   (cfg_ccw_i),
    .cfg_hold_i  (cfg_hold_i),
    .cfg_zero_i  (cfg_zero_i),
    .cfg_oe_i    (cfg_oe_i),
    .step_evt_o  (step_evt_w),
    .pend_mode_o (pend_mode_w),
    .pend_ccw_o  (pend_ccw_w),
    .zero_now_o  (zero_now_w),
    .zero_q_o    (zero_q_w),
    .hold_q_o    (hold_q_w),
    .oe_q_o      (oe_q_w),
    .stb_rise_o  (stb_rise_w)
  );

  stepseq_phase #(.PW(PW)) u_phase (
    .clk         (clk),
    .rst         (rst),
    .step_evt_i  (step_evt_w),
    .zero_i      (zero_now_w),
    .pend_mode_i (pend_mode_w),
    .pend_ccw_i  (pend_ccw_w),
    .pos_o       (pos_w),
    .act_mode_o  (act_mode_w)
  );

  stepseq_drive #(.PW(PW), .AMPW(AMPW)) u_drive (
    .clk        (clk),
    .rst        (rst),
    .pos_i      (pos_w),
    .act_mode_i (act_mode_w),
    .oe_i       (oe_q_w),
    .coil_o     (coil_w),
    .hiz_o      (hiz_o)
  );

  assign coil_a_o = $signed(coil_w[0]);
  assign coil_b_o = $signed(coil_w[1]);
endmodule

// File: rtl/step_phase_seq_chk.sv
module step_phase_seq_chk
  import stepseq_pkg::*;
#(
  parameter int PW   = 8,
  parameter int AMPW = 9
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   strobe_i,
  input logic                   cfg_oe_i,
  input logic                   hiz_o,
  input logic signed [AMPW-1:0] coil_a_o,
  input logic signed [AMPW-1:0] coil_b_o,
  input logic                   hold_q,
  input logic                   stb_rise,
  input logic                   zero_q,
  input logic [PW-1:0]          pos,
  input exc_mode_e              act_mode,
  input exc_mode_e              pend_mode
);
  localparam logic signed [AMPW-1:0] FULL = AMPW'((1 << (AMPW - 1)) - 1);

  logic [PW-1:0] pos_d;
  logic [PW-1:0] dpos;

  always_ff @(posedge clk) pos_d <= pos;
  assign dpos = pos - pos_d;

  AST_OFF_SETS_HIZ: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_i) && !cfg_oe_i |-> ##2 hiz_o); // R11

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
    hold_q && !stb_rise |=> $stable(pos)); // R8

  AST_ZERO_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    zero_q && $past(zero_q) && $past(zero_q, 2) |-> (coil_a_o == FULL) && (coil_b_o == '0)); // R10

  AST_FINE_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    !zero_q && !stb_rise && pend_mode == EXC_MICRO_FINE && act_mode == EXC_MICRO_FINE
    |=> (dpos == '0) || (dpos == PW'(1)) || (dpos == '1)); // R3
endmodule

bind step_phase_seq step_phase_seq_chk #(.PW(PW), .AMPW(AMPW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .strobe_i  (strobe_i),
  .cfg_oe_i  (cfg_oe_i),
  .hiz_o     (hiz_o),
  .coil_a_o  (coil_a_o),
  .coil_b_o  (coil_b_o),
  .hold_q    (hold_q_w),
  .stb_rise  (stb_rise_w),
  .zero_q    (zero_q_w),
  .pos       (pos_w),
  .act_mode  (act_mode_w),
  .pend_mode (pend_mode_w)
);

// File: tb/step_phase_seq_tb.sv
`timescale 1ns/1ps
module step_phase_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_i = 1'b0;
  logic strobe_i = 1'b0;
  logic [2:0] cfg_mode_i = 3'd3;
  logic cfg_ccw_i = 1'b0;
  logic cfg_hold_i = 1'b0;
  logic cfg_zero_i = 1'b0;
  logic cfg_oe_i = 1'b0;
  logic signed [8:0] coil_a_o;
  logic signed [8:0] coil_b_o;
  logic hiz_o;

  int checks = 0;
  int failures = 0;
  int bpos = 0, bact = 3, bpend = 3, bdir = 0, bzero = 0;

  always #2.5 clk = ~clk;

  step_phase_seq u_dut (
    .clk(clk), .rst(rst), .step_i(step_i), .strobe_i(strobe_i),
    .cfg_mode_i(cfg_mode_i), .cfg_ccw_i(cfg_ccw_i), .cfg_hold_i(cfg_hold_i),
    .cfg_zero_i(cfg_zero_i), .cfg_oe_i(cfg_oe_i),
    .coil_a_o(coil_a_o), .coil_b_o(coil_b_o), .hiz_o(hiz_o)
  );

  function automatic int tbl(int u);
    int num, den;
    den = 20480 - u * (128 - u);
    num = 255 * 4 * u * (128 - u);
    return (num + den / 2) / den;
  endfunction

  function automatic int amp(int ph);
    int p, q, r, m;
    p = ph & 255; q = p >> 6; r = p & 63;
    m = (q % 2 == 1) ? tbl(64 - r) : tbl(r);
    return (q >= 2) ? -m : m;
  endfunction

  function automatic int exp_a();
    int q = (bpos & 255) >> 6;
    if ((bact <= 1) && ((bpos & 63) == 32)) return (q == 0 || q == 3) ? 255 : -255;
    return amp(bpos + 64);
  endfunction

  function automatic int exp_b();
    int q = (bpos & 255) >> 6;
    if ((bact <= 1) && ((bpos & 63) == 32)) return (q <= 1) ? 255 : -255;
    return amp(bpos);
  endfunction

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic chk_pos(string tag);
    chk({tag, " coil A"}, int'(coil_a_o), exp_a());
    chk({tag, " coil B"}, int'(coil_b_o), exp_b());
  endtask

  task automatic model_step();
    int low, q, lq, st;
    bit changed, grid;
    if (bzero != 0) return;
    low = bpos & 63; q = bpos >> 6;
    changed = (bpend != bact);
    grid = (bpend == 0) ? (low == 32) : ((bpend <= 2) ? (low % 32 == 0) : 1'b1);
    if ((bpend <= 2) && (changed || !grid) && (low != 32)) begin
      if (bdir == 0) lq = (low < 32) ? q : q + 1;
      else           lq = (low > 32) ? q : q - 1;
      bpos = ((lq & 3) << 6) | 32;
    end else begin
      st = (bpend == 0) ? 64 : (bpend <= 2) ? 32 : (bpend == 4) ? 2 : 1;
      bpos = (bdir != 0) ? ((bpos - st) & 255) : ((bpos + st) & 255);
    end
    bact = bpend;
  endtask

  task automatic cfg(int m, int d, int h, int z, int o);
    @(negedge clk);
    cfg_mode_i = 3'(m); cfg_ccw_i = d[0]; cfg_hold_i = h[0];
    cfg_zero_i = z[0]; cfg_oe_i = o[0];
    strobe_i = 1'b1;
    repeat (2) @(negedge clk);
    strobe_i = 1'b0;
    repeat (4) @(negedge clk);
    if (m <= 4) bpend = m;
    bdir = d; bzero = z;
    if (z != 0) bpos = 0;
  endtask

  task automatic step();
    @(negedge clk); step_i = 1'b1;
    repeat (3) @(negedge clk); step_i = 1'b0;
    repeat (5) @(negedge clk);
    model_step();
  endtask

  task automatic raw_set(logic v);
    @(negedge clk); step_i = v;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 coil A", int'(coil_a_o), 255);
    chk("R1 coil B", int'(coil_b_o), 0);
    chk("R1 hiz", int'(hiz_o), 1);

    cfg(3, 0, 0, 0, 1);
    chk("R11 hiz cleared", int'(hiz_o), 0);

    // R2 full cycle of fine steps, R4 increasing direction
    for (int i = 0; i < 256; i++) begin
      step();
      chk_pos("R2 sweep");
    end

    // R5 direction latched but not yet applied
    cfg(3, 1, 0, 0, 1);
    chk_pos("R5 no change before step");
    for (int i = 0; i < 16; i++) begin
      step();
      chk_pos("R4 reverse");
    end

    // R3 coarse microstep
    cfg(4, 0, 0, 0, 1);
    for (int i = 0; i < 12; i++) begin
      step();
      chk_pos("R3 coarse micro");
    end

    // R7 entry into half-step from off-grid, then R3 half steps
    cfg(2, 0, 0, 0, 1);
    step();
    chk_pos("R7 half landing");
    for (int i = 0; i < 10; i++) begin
      step();
      chk_pos("R3 half");
    end

    // R6 half-step full torque
    cfg(1, 0, 0, 0, 1);
    for (int i = 0; i < 10; i++) begin
      step();
      chk_pos("R6 half full torque");
    end

    // R6 and R7 two-phase, both directions
    cfg(0, 1, 0, 0, 1);
    for (int i = 0; i < 6; i++) begin
      step();
      chk_pos("R6 two-phase reverse");
    end
    cfg(0, 0, 0, 0, 1);
    for (int i = 0; i < 6; i++) begin
      step();
      chk_pos("R6 two-phase forward");
    end

    // R10 zeroing
    cfg(3, 0, 0, 1, 1);
    chk("R10 zero coil A", int'(coil_a_o), 255);
    chk("R10 zero coil B", int'(coil_b_o), 0);
    for (int i = 0; i < 3; i++) step();
    chk_pos("R10 steps ignored");
    cfg(3, 0, 0, 0, 1);
    step();
    chk_pos("R10 resume from origin");

    // R7 entry into half-step while on a diagonal takes a normal step
    for (int i = 0; i < 31; i++) step();
    chk_pos("R7 reached diagonal");
    cfg(2, 0, 0, 0, 1);
    step();
    chk("R7 diagonal entry coil A", int'(coil_a_o), 0);
    chk("R7 diagonal entry coil B", int'(coil_b_o), 255);
    chk_pos("R7 diagonal entry model");

    // R7 two-phase entry from an axis, reverse direction
    cfg(0, 1, 0, 0, 1);
    step();
    chk_pos("R7 two-phase axis entry");

    // R8 hold captured low, R9 release with external high steps
    cfg(3, 0, 0, 0, 1);
    step();
    cfg(3, 0, 1, 0, 1);
    for (int i = 0; i < 3; i++) begin
      raw_set(1'b1);
      raw_set(1'b0);
    end
    chk_pos("R8 held low, pulses ignored");
    raw_set(1'b1);
    chk_pos("R8 held low, external high");
    cfg(3, 0, 0, 0, 1);
    model_step();
    chk_pos("R9 release steps");

    // R8 hold captured high, R9 release with external high does not step
    cfg(3, 0, 1, 0, 1);
    raw_set(1'b0); raw_set(1'b1); raw_set(1'b0); raw_set(1'b1);
    chk_pos("R8 held high, toggles ignored");
    cfg(3, 0, 0, 0, 1);
    chk_pos("R9 release no step");
    raw_set(1'b0);
    step();
    chk_pos("R9 next edge steps");

    // R11 output-off keeps tracking
    cfg(3, 0, 0, 0, 0);
    chk("R11 hiz set", int'(hiz_o), 1);
    for (int i = 0; i < 5; i++) begin
      step();
      chk_pos("R11 advance while off");
    end
    cfg(3, 0, 0, 0, 1);
    chk("R11 hiz cleared again", int'(hiz_o), 0);
    chk_pos("R11 advanced position shown");

    // R12 invalid code keeps the pending mode
    cfg(0, 0, 0, 0, 1);
    step();
    cfg(7, 0, 0, 0, 1);
    step();
    chk_pos("R12 invalid code ignored");
    cfg(5, 0, 0, 0, 1);
    step();
    chk_pos("R12 invalid code 5 ignored");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule